// File: doc/BRIEF.md
# PWM Dimming Edge Sequencer

This block times the edges of a PWM dimming cycle for a resonant LED power stage. It runs once the soft-start-done flag is high. It takes a dimming PWM input that is already synchronized to its clock and drives three outputs from it. The first is the LED switch drive. The second is a loop-connect enable that couples the current-error amplifier to its hold capacitor. The third is a power-stage-off request. It also produces a slew-limited power command for the oscillator control path.

At a falling dimming edge the LED switch opens at once. The power stage keeps running for a tail time, so the current loop stays in control at low duties. The tail grows with the running average of the fraction of time the dimming input is low. A symmetric up/down ramp follows the power-stage-off state. The power command is the lower of that ramp and the held loop command. The stage therefore winds down softly and comes back to the same operating point.

A five-state machine drives the outputs. IDLE holds while soft-start is not done. ARM means the LED is on and the loop-connect delay is still counting. LIT means the LED is on and the loop is connected. TAIL means the LED is off and the turn-off delay is running. DARK means the power stage is off. The transitions are:

- IDLE to ARM or DARK when soft-start completes, depending on the dimming level.
- ARM to LIT when the connect delay expires.
- ARM or LIT to TAIL on a low dimming sample.
- TAIL to DARK when the tail count reaches the latched target.
- TAIL or DARK to ARM on a high dimming sample.
- Any state to IDLE when soft-start-done drops.

Top module: `dim_edge_seq`

## Requirements
- R1: While `ss_done` is high, `led_sw` equals the `dim_in` value sampled at the previous rising clock edge.
- R2: `loop_link` rises exactly LINK_DLY cycles after `led_sw` rises, provided `dim_in` stays high. It falls in the same cycle as `led_sw` when that fall is caused by a low dimming sample.
- R3: `stage_off` is never high while `led_sw` is high, and it falls in the same cycle that `led_sw` rises.
- R4: After `led_sw` falls on a low dimming sample, `stage_off` rises exactly T cycles later, where T is the target latched at that edge. A high dimming sample before then cancels the rise.
- R5: The off-fraction accumulator A starts at 0 and, in each cycle with `ss_done` high, becomes A − (A >> AVG_SH) + (dim_in ? 0 : 2^AVG_W >> AVG_SH). The target is T = OFS + ((25·OFS·min(A, 2^AVG_W)) >> AVG_W). This spans OFS when the input is always high and 26·OFS when it is always low.
- R6: In each cycle with `ss_done` high, the slew ramp moves STEP toward 0 when `stage_off` is high and STEP toward 2^CW−1 when it is low, saturating at both ends.
- R7: `pwr_cmd` equals the minimum of the slew ramp and `loop_cmd`.
- R8: While `ss_done` is low, the cycle after shows `led_sw` low, `loop_link` high and `stage_off` low, and the ramp is reset to full scale. Dimming edges in that time have no effect.
- R9: After reset, `led_sw` is 0, `loop_link` is 1, `stage_off` is 0, `pwr_cmd` equals `loop_cmd`, and the accumulator is 0.
- R10: With `dim_in` held high (non-dimming), `led_sw` and `loop_link` stay high and `stage_off` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ss_done | input | 1 | Soft-start complete; enables sequencing |
| dim_in | input | 1 | Synchronized dimming PWM level |
| loop_cmd | input | CW | Held current-loop command |
| led_sw | output | 1 | LED string switch drive |
| loop_link | output | 1 | Couples amplifier output to hold capacitor |
| stage_off | output | 1 | Power stage off request |
| pwr_cmd | output | CW | Slew-limited power command |

## Verification
The bench drives several kinds of dimming pattern:

- A long high stretch shows non-dimming hold and the minimum tail length.
- A long low stretch followed by a one-cycle pulse shows the tail near full scale, and shows a rise cut short before the loop connects.
- Random high and low runs from one cycle to several hundred cycles separate the edge timing from the averaging. Short runs also hit cancelled tails and partial ramps.
- Random drops of soft-start-done and changes of the loop command test the idle override and which side of the minimum wins.

// File: rtl/dim_seq_pkg.sv
package dim_seq_pkg;

    // Sequencer states; see the brief for meaning and transitions.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARM  = 3'd1,
        ST_LIT  = 3'd2,
        ST_TAIL = 3'd3,
        ST_DARK = 3'd4
    } seq_state_t;

endpackage

// File: rtl/dim_duty_avg.sv
module dim_duty_avg #(
    parameter int AVG_W  = 12,
    parameter int AVG_SH = 4,
    parameter int OFS    = 4,
    parameter int TW     = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dim_in,
    output logic [TW-1:0] tgt_o
);
    localparam int ACC_W = AVG_W + 1;
    localparam int FULL  = 1 << AVG_W;
    localparam int SPAN  = 25 * OFS;
    localparam int PW    = ACC_W + $clog2(SPAN + 1);
    localparam logic [ACC_W-1:0] INC    = ACC_W'(FULL >> AVG_SH);
    localparam logic [ACC_W-1:0] FULL_V = ACC_W'(FULL);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] frac;
    logic [PW-1:0]    prod;

    // First-order low-pass of the off indicator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc - (acc >> AVG_SH) + (dim_in ? '0 : INC);
        end
    end

    always_comb begin
        frac  = (acc > FULL_V) ? FULL_V : acc;
        prod  = PW'(frac) * PW'(SPAN);
        tgt_o = TW'(OFS) + TW'(prod >> AVG_W);
    end

endmodule

// File: rtl/dim_slew_ramp.sv
module dim_slew_ramp #(
    parameter int CW   = 10,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          down,
    input  logic [CW-1:0] loop_cmd,
    output logic [CW-1:0] pwr_cmd
);
    localparam logic [CW-1:0] TOP  = {CW{1'b1}};
    localparam logic [CW-1:0] STPV = CW'(STEP);

    logic [CW-1:0] ramp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp <= TOP;
        end else if (!en) begin
            ramp <= TOP;
        end else if (down) begin
            ramp <= (ramp < STPV) ? '0 : ramp - STPV;
        end else begin
            ramp <= (ramp > TOP - STPV) ? TOP : ramp + STPV;
        end
    end

    assign pwr_cmd = (ramp < loop_cmd) ? ramp : loop_cmd;

endmodule

// File: rtl/dim_edge_fsm.sv
module dim_edge_fsm
    import dim_seq_pkg::*;
#(
    parameter int LINK_DLY = 300,
    parameter int CNT_W    = 9,
    parameter int TW       = 7,
    parameter int OFS      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ss_done,
    input  logic          dim_in,
    input  logic [TW-1:0] tgt_i,
    output logic          led_sw,
    output logic          loop_link,
    output logic          stage_off
);
    localparam logic [CNT_W-1:0] LINK_LAST = CNT_W'(LINK_DLY - 1);

    seq_state_t       st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [TW-1:0]    tgt_q, tgt_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            tgt_q <= TW'(OFS);
        end else begin
            st    <= st_nx;
            cnt   <= cnt_nx;
            tgt_q <= tgt_nx;
        end
    end

    // Next state
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt + 1'b1;
        tgt_nx = tgt_q;
        if (!ss_done) begin
            st_nx  = ST_IDLE;
            cnt_nx = '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    cnt_nx = '0;
                    st_nx  = dim_in ? ST_ARM : ST_DARK;
                end
                ST_ARM: begin
                    if (!dim_in) begin
                        st_nx  = ST_TAIL;
                        cnt_nx = '0;
                        tgt_nx = tgt_i;
                    end else if (cnt == LINK_LAST) begin
                        st_nx = ST_LIT;
                    end
                end
                ST_LIT: begin
                    cnt_nx = cnt;
                    if (!dim_in) begin
                        st_nx  = ST_TAIL;
                        cnt_nx = '0;
                        tgt_nx = tgt_i;
                    end
                end
                ST_TAIL: begin
                    if (dim_in) begin
                        st_nx  = ST_ARM;
                        cnt_nx = '0;
                    end else if (cnt == CNT_W'(tgt_q) - 1'b1) begin
                        st_nx = ST_DARK;
                    end
                end
                ST_DARK: begin
                    cnt_nx = cnt;
                    if (dim_in) begin
                        st_nx  = ST_ARM;
                        cnt_nx = '0;
                    end
                end
                default: begin
                    st_nx  = ST_IDLE;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        led_sw    = 1'b0;
        loop_link = 1'b0;
        stage_off = 1'b0;
        unique case (st)
            ST_IDLE: loop_link = 1'b1;
            ST_ARM:  led_sw    = 1'b1;
            ST_LIT: begin
                led_sw    = 1'b1;
                loop_link = 1'b1;
            end
            ST_TAIL: ;
            ST_DARK: stage_off = 1'b1;
            default: loop_link = 1'b1;
        endcase
    end

endmodule

// File: rtl/dim_edge_seq.sv
module dim_edge_seq #(
    parameter int CW       = 10,
    parameter int STEP     = 8,
    parameter int LINK_DLY = 300,
    parameter int OFS      = 4,
    parameter int AVG_W    = 12,
    parameter int AVG_SH   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ss_done,
    input  logic          dim_in,
    input  logic [CW-1:0] loop_cmd,
    output logic          led_sw,
    output logic          loop_link,
    output logic          stage_off,
    output logic [CW-1:0] pwr_cmd
);
    localparam int TGT_MAX = 26 * OFS;
    localparam int TW      = $clog2(TGT_MAX + 1);
    localparam int CNT_MAX = (LINK_DLY > TGT_MAX) ? LINK_DLY : TGT_MAX;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [TW-1:0] tgt;

    dim_duty_avg #(
        .AVG_W (AVG_W),
        .AVG_SH(AVG_SH),
        .OFS   (OFS),
        .TW    (TW)
    ) u_avg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ss_done),
        .dim_in(dim_in),
        .tgt_o (tgt)
    );

    dim_edge_fsm #(
        .LINK_DLY(LINK_DLY),
        .CNT_W   (CNT_W),
        .TW      (TW),
        .OFS     (OFS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_done  (ss_done),
        .dim_in   (dim_in),
        .tgt_i    (tgt),
        .led_sw   (led_sw),
        .loop_link(loop_link),
        .stage_off(stage_off)
    );

    dim_slew_ramp #(
        .CW  (CW),
        .STEP(STEP)
    ) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ss_done),
        .down    (stage_off),
        .loop_cmd(loop_cmd),
        .pwr_cmd (pwr_cmd)
    );

endmodule

// File: rtl/dim_edge_seq_chk.sv
module dim_edge_seq_chk #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ss_done,
    input logic          dim_in,
    input logic [CW-1:0] loop_cmd,
    input logic          led_sw,
    input logic          loop_link,
    input logic          stage_off,
    input logic [CW-1:0] pwr_cmd
);
    p_led_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_done && dim_in) |=> led_sw);

    p_led_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !dim_in |=> !led_sw);

    p_link_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(led_sw) && $past(ss_done)) |-> (!loop_link && !stage_off));

    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        led_sw |-> !stage_off);

    p_ramp_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_off && $past(stage_off) && $past(ss_done) && $stable(loop_cmd))
        |-> (pwr_cmd <= $past(pwr_cmd)));

    p_cmd_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cmd <= loop_cmd);

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_done |=> (!led_sw && loop_link && !stage_off));

endmodule

bind dim_edge_seq dim_edge_seq_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ss_done  (ss_done),
    .dim_in   (dim_in),
    .loop_cmd (loop_cmd),
    .led_sw   (led_sw),
    .loop_link(loop_link),
    .stage_off(stage_off),
    .pwr_cmd  (pwr_cmd)
);

// File: tb/sim_dim_edge_seq.sv
`timescale 1ns/1ps
module sim_dim_edge_seq;
    localparam int CW    = 10;
    localparam int STEP  = 8;
    localparam int LDLY  = 300;
    localparam int OFS   = 4;
    localparam int AW    = 12;
    localparam int SH    = 4;
    localparam int TOP   = (1 << CW) - 1;
    localparam int FULLA = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ss_done = 1'b0;
    logic          dim_in = 1'b0;
    logic [CW-1:0] loop_cmd = CW'(600);
    logic          led_sw, loop_link, stage_off;
    logic [CW-1:0] pwr_cmd;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    dim_edge_seq #(
        .CW(CW), .STEP(STEP), .LINK_DLY(LDLY), .OFS(OFS), .AVG_W(AW), .AVG_SH(SH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ss_done(ss_done), .dim_in(dim_in),
        .loop_cmd(loop_cmd), .led_sw(led_sw), .loop_link(loop_link),
        .stage_off(stage_off), .pwr_cmd(pwr_cmd)
    );

    // Reference model state, built from the requirements
    int m_led, m_link, m_off, m_ramp, m_acc, m_hi, m_lo, m_tgt, m_idle;

    function automatic int tgt_of(input int a);
        int f;
        f = (a > FULLA) ? FULLA : a;
        return OFS + ((25 * OFS * f) >> AW);
    endfunction

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: %s got %0d exp %0d", tag, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_idle = 1; m_led = 0; m_link = 1; m_off = 0; m_ramp = TOP;
            m_acc = 0; m_hi = 0; m_lo = 0; m_tgt = OFS;
        end else if (!ss_done) begin
            m_idle = 1; m_led = 0; m_link = 1; m_off = 0; m_ramp = TOP;
            m_hi = 0; m_lo = 0;
        end else begin
            if (m_off != 0) m_ramp = (m_ramp < STEP) ? 0 : m_ramp - STEP;
            else            m_ramp = (m_ramp > TOP - STEP) ? TOP : m_ramp + STEP;
            if (dim_in) begin
                if (m_led == 0) begin
                    m_led = 1; m_link = 0; m_off = 0; m_hi = 0;
                end else if (m_link == 0) begin
                    m_hi++;
                    if (m_hi == LDLY) m_link = 1;
                end
            end else begin
                if (m_idle != 0) begin
                    m_off = 1; m_link = 0;
                end else if (m_led != 0) begin
                    m_led = 0; m_link = 0; m_lo = 0; m_tgt = tgt_of(m_acc);
                end else if (m_off == 0) begin
                    m_lo++;
                    if (m_lo == m_tgt) m_off = 1;
                end
            end
            m_idle = 0;
            m_acc = m_acc - (m_acc >> SH) + (dim_in ? 0 : (FULLA >> SH));
        end
    end

    // Continuous comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string t;
            t = ss_done ? "R1" : "R8";
            check(t, "led_sw", int'(led_sw), m_led);
            check(ss_done ? "R2" : "R8", "loop_link", int'(loop_link), m_link);
            check(ss_done ? "R3/R4" : "R8", "stage_off", int'(stage_off), m_off);
            check("R6/R7", "pwr_cmd", int'(pwr_cmd), min2(m_ramp, int'(loop_cmd)));
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic measure_tail(input string tag);
        int cnt;
        dim_in = 1'b0;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!stage_off && cnt < 500);
        #1;
        check(tag, "tail cycles", cnt - 1, m_tgt);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        // R9: reset state
        step(3);
        check("R9", "led_sw", int'(led_sw), 0);
        check("R9", "loop_link", int'(loop_link), 1);
        check("R9", "stage_off", int'(stage_off), 0);
        check("R9", "pwr_cmd", int'(pwr_cmd), 600);
        rst_n = 1'b1;
        step(3);
        // R8: dimming edges ignored while soft-start not done
        dim_in = 1'b1; step(5); dim_in = 1'b0; step(5);
        check("R8", "led_sw idle", int'(led_sw), 0);
        check("R8", "loop_link idle", int'(loop_link), 1);
        // R10: non-dimming
        ss_done = 1'b1; dim_in = 1'b1;
        step(2000);
        check("R10", "led_sw held", int'(led_sw), 1);
        check("R10", "loop_link held", int'(loop_link), 1);
        check("R10", "stage_off held", int'(stage_off), 0);
        // R5: minimum tail after long high
        measure_tail("R5");
        check("R5", "min target", m_tgt, OFS);
        // R5: near-maximum tail after long low plus a one-cycle pulse
        step(2000);
        check("R6", "ramp floor", int'(pwr_cmd), 0);
        dim_in = 1'b1; step(1);
        check("R3", "stage_off at rise", int'(stage_off), 0);
        measure_tail("R5");
        check("R5", "long-low target above 90", int'(m_tgt > 90), 1);
        // R2: connect delay
        dim_in = 1'b1; step(LDLY);
        check("R2", "link before delay", int'(loop_link), 0);
        step(1);
        check("R2", "link after delay", int'(loop_link), 1);
        // Random segments
        for (int s = 0; s < 160; s++) begin
            int r;
            r = $urandom_range(0, 11);
            if ($urandom_range(0, 3) == 0) loop_cmd = CW'($urandom_range(0, TOP));
            if (r == 0) begin
                ss_done = 1'b0;
                dim_in = 1'($urandom_range(0, 1));
                step($urandom_range(2, 40));
                ss_done = 1'b1;
            end else if (r < 5) begin
                dim_in = ~dim_in;
                step($urandom_range(1, 8));
            end else begin
                dim_in = ~dim_in;
                step($urandom_range(9, 400));
            end
        end
        step(5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cycles > 150000);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: cycles got %0d exp below 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule